// File: doc/BRIEF.md
# SPI Slave Desynchronization Detector

This block sits beside the shift engine of an SPI master. It watches the handshake signal that a slave drives to say it is taking part in a word exchange. A slave that misses one or more SPI clock edges loses its bit alignment. Such a slave may release its enable too early, in the middle of a word. It may also keep its enable asserted long after the master has shifted the last bit. The block detects both cases and records them in a sticky flag.

The shift engine supplies three single-cycle strobes: an SPI clock tick, the start of a word, and the end of the last shifted bit. The last bit is the final data bit or, when parity is used, the parity bit. The active-low enable from the slave is brought into the system clock domain by a synchronizer. Once the last bit is done, a post-transfer timer counts SPI clock ticks. If the slave has not released its enable by the time the timer reaches a programmable 8-bit limit, the flag is set. A level interrupt request follows the flag while the interrupt enable is on. Software clears the flag with a one-cycle clear strobe.

Top module: `spi_desync_monitor`

## Requirements
- R1: While reset is asserted and after it is released, `desyncFlag` and `desyncIrq` are 0 and the monitor is idle.
- R2: `slvEnaN` is active-low (0 = slave enabled). It passes through a two-stage synchronizer, so a change driven between clock edges affects the flag no earlier than the third rising edge after it.
- R3: If the synchronized enable goes inactive while a word is in progress (after `xferStart` and before `lastBitDone`), `desyncFlag` is set.
- R4: When `lastBitDone` arrives in the same cycle in which the synchronized enable first reads inactive, the word counts as complete and no flag is set.
- R5: After `lastBitDone`, `sclkTick` pulses are counted. With the enable still active, the flag is set on the tick numbered max(`timeoutLimit`,1); a limit of 0 acts as 1. Ticks seen during the word itself are not counted.
- R6: If the enable goes inactive before the timeout is reached, the watch ends without setting the flag, and later ticks have no effect.
- R7: `desyncFlag` is sticky. A one-cycle `clrDesync` clears it on the next edge, but a detection in the same cycle as a clear leaves it set.
- R8: `desyncIrq` is high exactly while `desyncFlag` and `irqEnable` are both 1.
- R9: Outside a word and its post-transfer watch, changes of the enable and `sclkTick` pulses never set the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclkTick | input | 1 | One-cycle strobe per SPI clock period |
| xferStart | input | 1 | One-cycle strobe at the start of a word |
| lastBitDone | input | 1 | One-cycle strobe when the last bit (data or parity) has been shifted |
| slvEnaN | input | 1 | Asynchronous active-low enable from the slave |
| timeoutLimit | input | CNT_W (8) | Post-transfer timeout in SPI clock ticks |
| irqEnable | input | 1 | Interrupt enable |
| clrDesync | input | 1 | One-cycle strobe that clears the flag |
| desyncFlag | output | 1 | Sticky desynchronization flag |
| desyncIrq | output | 1 | Interrupt request, level |

## Verification
The timeout path is swept over limits 0 to 12 and near the top of the 8-bit range. For each limit, one tick short of the limit must leave the flag clear and the next tick must set it. This separates an off-by-one in the counter and a wrong treatment of limit 0 from correct behaviour. For each limit a release of the enable one tick before expiry is also tried, which shows whether the watch really stops. Single cases cover:
- an enable drop in mid-word, with the flag sampled at the second and third edge to pin down the synchronizer depth;
- an enable drop that coincides with the last bit;
- enable toggling and ticks while idle;
- a clear that meets a new detection in the same cycle.

// File: rtl/desync_pkg.sv
package desync_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_WORD = 2'd1,
    PH_WAIT = 2'd2
  } phase_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic cntClear;
    logic cntInc;
    logic desyncEvt;
  } ctrl_strb_t;

endpackage

// File: rtl/desync_dp.sv
module desync_dp
  import desync_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             slvEnaN,
  input  logic [CNT_W-1:0] timeoutLimit,
  input  logic             irqEnable,
  input  logic             clrDesync,
  input  ctrl_strb_t       strb,
  output logic             enaActive,
  output logic             cntHit,
  output logic [CNT_W-1:0] cnt,
  output logic             desyncFlag,
  output logic             desyncIrq
);

  localparam int CMP_W = CNT_W + 1;

  // Enable synchronizer, reset to the inactive (high) level
  logic [SYNC_STAGES-1:0] syncQ;

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[0] <= 1'b1;
          else       syncQ[0] <= slvEnaN;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[s] <= 1'b1;
          else       syncQ[s] <= syncQ[s-1];
        end
      end
    end
  endgenerate

  assign enaActive = ~syncQ[SYNC_STAGES-1];

  // Post-transfer tick counter
  logic [CMP_W-1:0] cntNext;

  assign cntNext = {1'b0, cnt} + CMP_W'(1);
  assign cntHit  = cntNext >= {1'b0, timeoutLimit};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              cnt <= '0;
    else if (strb.cntClear) cnt <= '0;
    else if (strb.cntInc)   cnt <= cntNext[CNT_W-1:0];
  end

  // Sticky flag: a detection outranks a clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               desyncFlag <= 1'b0;
    else if (strb.desyncEvt) desyncFlag <= 1'b1;
    else if (clrDesync)      desyncFlag <= 1'b0;
  end

  assign desyncIrq = desyncFlag & irqEnable;

endmodule

// File: rtl/desync_ctrl.sv
module desync_ctrl
  import desync_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       xferStart,
  input  logic       lastBitDone,
  input  logic       sclkTick,
  input  logic       enaActive,
  input  logic       cntHit,
  output phase_t     phase,
  output ctrl_strb_t strb
);

  phase_t phaseNext;

  always_comb begin
    phaseNext = phase;
    strb      = '0;
    unique case (phase)
      PH_IDLE: begin
        if (xferStart) phaseNext = PH_WORD;
      end
      PH_WORD: begin
        if (lastBitDone) begin
          strb.cntClear = 1'b1;
          phaseNext     = PH_WAIT;
        end else if (!enaActive) begin
          strb.desyncEvt = 1'b1;
          phaseNext      = PH_IDLE;
        end
      end
      PH_WAIT: begin
        if (!enaActive) begin
          phaseNext = PH_IDLE;
        end else if (sclkTick) begin
          if (cntHit) begin
            strb.desyncEvt = 1'b1;
            phaseNext      = PH_IDLE;
          end else begin
            strb.cntInc = 1'b1;
          end
        end
      end
      default: phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= phaseNext;
  end

endmodule

// File: rtl/spi_desync_monitor.sv
module spi_desync_monitor
  import desync_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclkTick,
  input  logic             xferStart,
  input  logic             lastBitDone,
  input  logic             slvEnaN,
  input  logic [CNT_W-1:0] timeoutLimit,
  input  logic             irqEnable,
  input  logic             clrDesync,
  output logic             desyncFlag,
  output logic             desyncIrq
);

  ctrl_strb_t       strb;
  phase_t           phase;
  logic             enaActive;
  logic             cntHit;
  logic [CNT_W-1:0] cnt;
  logic             desyncEvt;

  assign desyncEvt = strb.desyncEvt;

  desync_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .xferStart  (xferStart),
    .lastBitDone(lastBitDone),
    .sclkTick   (sclkTick),
    .enaActive  (enaActive),
    .cntHit     (cntHit),
    .phase      (phase),
    .strb       (strb)
  );

  desync_dp #(
    .CNT_W      (CNT_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .slvEnaN     (slvEnaN),
    .timeoutLimit(timeoutLimit),
    .irqEnable   (irqEnable),
    .clrDesync   (clrDesync),
    .strb        (strb),
    .enaActive   (enaActive),
    .cntHit      (cntHit),
    .cnt         (cnt),
    .desyncFlag  (desyncFlag),
    .desyncIrq   (desyncIrq)
  );

endmodule

// File: rtl/desync_checker.sv
module desync_checker
  import desync_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             clrDesync,
  input logic             irqEnable,
  input logic [CNT_W-1:0] timeoutLimit,
  input logic             desyncEvt,
  input phase_t           phase,
  input logic [CNT_W-1:0] cnt,
  input logic             desyncFlag,
  input logic             desyncIrq
);

  // R1
  a_r1_reset_clears: assert property (@(posedge clk)
    !rstN |=> !desyncFlag);

  // R7
  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (desyncFlag && !clrDesync) |=> desyncFlag);

  a_r7_clear_takes_effect: assert property (@(posedge clk) disable iff (!rstN)
    (clrDesync && !desyncEvt) |=> !desyncFlag);

  a_r7_event_beats_clear: assert property (@(posedge clk) disable iff (!rstN)
    desyncEvt |=> desyncFlag);

  // R8
  a_r8_irq_implies_flag: assert property (@(posedge clk) disable iff (!rstN)
    desyncIrq |-> desyncFlag);

  a_r8_irq_masked: assert property (@(posedge clk) disable iff (!rstN)
    !irqEnable |-> !desyncIrq);

  // R5
  a_r5_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_WAIT && timeoutLimit != '0) |-> (cnt < timeoutLimit));

  // R9
  a_r9_idle_no_event: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_IDLE) |-> !desyncEvt);

  a_r9_rise_needs_event: assert property (@(posedge clk) disable iff (!rstN)
    $rose(desyncFlag) |-> $past(desyncEvt));

endmodule

bind spi_desync_monitor desync_checker #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .clrDesync   (clrDesync),
  .irqEnable   (irqEnable),
  .timeoutLimit(timeoutLimit),
  .desyncEvt   (desyncEvt),
  .phase       (phase),
  .cnt         (cnt),
  .desyncFlag  (desyncFlag),
  .desyncIrq   (desyncIrq)
);

// File: tb/spi_desync_monitor_bench.sv
`timescale 1ns/1ps
module spi_desync_monitor_bench;

  localparam int CNT_W = 8;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             sclkTick = 1'b0;
  logic             xferStart = 1'b0;
  logic             lastBitDone = 1'b0;
  logic             slvEnaN = 1'b1;
  logic [CNT_W-1:0] timeoutLimit = '0;
  logic             irqEnable = 1'b0;
  logic             clrDesync = 1'b0;
  logic             desyncFlag;
  logic             desyncIrq;

  int testCount = 0;
  int failCount = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  spi_desync_monitor #(.CNT_W(CNT_W)) u_spi_desync_monitor (
    .clk         (clk),
    .rstN        (rstN),
    .sclkTick    (sclkTick),
    .xferStart   (xferStart),
    .lastBitDone (lastBitDone),
    .slvEnaN     (slvEnaN),
    .timeoutLimit(timeoutLimit),
    .irqEnable   (irqEnable),
    .clrDesync   (clrDesync),
    .desyncFlag  (desyncFlag),
    .desyncIrq   (desyncIrq)
  );

  // Inputs change and outputs are sampled 1 ns after each rising edge
  task automatic cyc(input int n = 1);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic check(input string req, input logic act, input logic exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic checkOuts(input string req, input logic expFlag);
    check({req, " flag"}, desyncFlag, expFlag);
    check({req, " irq"}, desyncIrq, expFlag & irqEnable);
  endtask

  task automatic enableSlave();
    slvEnaN = 1'b0;
    cyc(3);
  endtask

  task automatic releaseSlave();
    slvEnaN = 1'b1;
    cyc(3);
  endtask

  task automatic startWord();
    xferStart = 1'b1;
    cyc();
    xferStart = 1'b0;
    cyc();
  endtask

  task automatic endWord();
    lastBitDone = 1'b1;
    cyc();
    lastBitDone = 1'b0;
  endtask

  task automatic ticks(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      sclkTick = 1'b1;
      cyc();
      sclkTick = 1'b0;
      cyc(gap);
    end
  endtask

  task automatic clearFlag();
    clrDesync = 1'b1;
    cyc();
    clrDesync = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failCount++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    cyc(2);
    checkOuts("R1 in reset", 1'b0);
    rstN = 1'b1;
    cyc(2);
    checkOuts("R1 after reset", 1'b0);

    // R9: idle activity is ignored
    irqEnable = 1'b1;
    timeoutLimit = 8'd1;
    enableSlave();
    ticks(4, 0);
    releaseSlave();
    enableSlave();
    ticks(3, 1);
    checkOuts("R9 idle toggling and ticks", 1'b0);
    releaseSlave();

    // R2/R3: mid-word drop, synchronizer depth
    enableSlave();
    startWord();
    ticks(5, 1);
    checkOuts("R3 no drop yet", 1'b0);
    slvEnaN = 1'b1;
    cyc(2);
    check("R2 flag after two edges", desyncFlag, 1'b0);
    cyc();
    check("R2 flag after three edges", desyncFlag, 1'b1);
    checkOuts("R3 mid-word drop", 1'b1);
    cyc(3);
    checkOuts("R7 sticky hold", 1'b1);
    clearFlag();
    checkOuts("R7 clear", 1'b0);

    // R4: drop coincides with last bit
    enableSlave();
    startWord();
    ticks(3, 0);
    slvEnaN = 1'b1;
    cyc(2);
    endWord();
    cyc(2);
    ticks(4, 0);
    checkOuts("R4 drop with last bit", 1'b0);

    // R5/R6/R8 sweep over the limit
    for (int sel = 0; sel < 16; sel++) begin
      int lim;
      int eff;
      lim = (sel < 13) ? sel : (sel == 13 ? 128 : (sel == 14 ? 254 : 255));
      eff = (lim == 0) ? 1 : lim;
      timeoutLimit = CNT_W'(lim);
      irqEnable = sel[0];

      // timeout reached
      enableSlave();
      startWord();
      ticks(sel % 4 + 2, 0);           // ticks during word do not count
      endWord();
      ticks(eff - 1, sel % 3);
      checkOuts($sformatf("R5 lim %0d one short", lim), 1'b0);
      ticks(1, 0);
      checkOuts($sformatf("R5 lim %0d expiry", lim), 1'b1);
      check($sformatf("R8 lim %0d irq", lim), desyncIrq, sel[0]);
      releaseSlave();
      checkOuts($sformatf("R9 lim %0d release after expiry", lim), 1'b1);
      clearFlag();
      checkOuts($sformatf("R7 lim %0d clear", lim), 1'b0);

      // release one tick before expiry
      enableSlave();
      startWord();
      endWord();
      ticks(eff - 1, 0);
      releaseSlave();
      ticks(eff + 1, 0);
      checkOuts($sformatf("R6 lim %0d early release", lim), 1'b0);
    end

    // R8: irq follows the enable while flag is set
    timeoutLimit = 8'd2;
    irqEnable = 1'b0;
    enableSlave();
    startWord();
    endWord();
    ticks(2, 0);
    checkOuts("R8 masked", 1'b1);
    irqEnable = 1'b1;
    cyc();
    check("R8 unmasked irq", desyncIrq, 1'b1);

    // R7: detection in the same cycle as a clear wins
    releaseSlave();
    enableSlave();
    startWord();
    endWord();
    ticks(1, 0);
    check("R7 flag still set before race", desyncFlag, 1'b1);
    sclkTick = 1'b1;
    clrDesync = 1'b1;
    cyc();
    sclkTick = 1'b0;
    clrDesync = 1'b0;
    checkOuts("R7 event beats clear", 1'b1);
    clearFlag();
    checkOuts("R7 clear after race", 1'b0);
    releaseSlave();

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule